// File: doc/BRIEF.md
# Accumulator Stored-Program Computer

A very small stored-program machine whose instructions and data share one 16-word by 8-bit memory. Every transfer between its registers passes over one common 8-bit bus. The machine has these registers:

- a 4-bit program counter
- a memory address register
- an instruction register
- an accumulator
- an operand register
- an output register

An adder/subtractor combines the accumulator with the operand register. A controller runs every instruction through the same six-step ring of timing states. In each state it raises a control word that names one bus driver and the registers that load from the bus.

Memory is filled through a preload port while the clear input is held low. When clear is released, the machine fetches from address 0. It stops at a halt instruction, raises `halted`, and holds all of its state until the next clear. Results are seen at the 8-bit output port, which changes only when an output instruction runs.

Top module: `acc_computer`

## Requirements
- R1: An instruction word carries its opcode in bits 7:4 and a memory address in bits 3:0.
- R2: Opcode 0000 loads the word at the addressed location into the accumulator.
- R3: Opcode 0001 first copies the addressed word into the operand register, then writes accumulator plus operand, modulo 256, back into the accumulator.
- R4: Opcode 0010 works in the same way but writes accumulator minus operand, modulo 256.
- R5: Opcode 0011 copies the accumulator to `out_port` at the clock edge that ends the fourth step of that instruction. `out_port` changes at no other time.
- R6: Opcode 1111 raises `halted` at the edge that ends its fourth step. After that, `halted` stays high and `out_port` stays unchanged until clear.
- R7: Any other opcode is a no-op that still takes six cycles.
- R8: Every instruction takes exactly six clock cycles. The first fetch after clear reads address 0. The program counter advances once per instruction and wraps from 15 to 0.
- R9: At most one source drives the shared bus in any cycle. Memory drives the bus only in the instruction-fetch step or the operand-read step, never in both.
- R10: A clock edge with `rst_n` low clears the program counter, instruction register, accumulator, operand register, output register, step counter and `halted`. Preload writes take effect only while `rst_n` is low and are ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low clear; also enables preload |
| pre_we | input | 1 | Preload write strobe (effective only during clear) |
| pre_addr | input | 4 | Preload memory address |
| pre_data | input | 8 | Preload memory data |
| out_port | output | 8 | Output register contents |
| halted | output | 1 | High once a halt instruction has run |

## Verification
The checker examines every cycle for:

- a single bus driver
- memory reads confined to the fetch and operand steps
- a one-hot step ring
- one program counter advance per instruction
- output changes and the rise of `halted` only after a fourth step
- `halted` and `out_port` frozen once halted

Only the bench's programs can show that the arithmetic is correct, including wrap-around in both directions. The same holds for the exact cycle at which the output and halt appear, for no-op opcodes keeping six-cycle timing, and for wrap of the program counter. They also cover preload writes being ignored while running and a clear in mid-program. Each of these is compared cycle by cycle with a behavioural model of the machine.

// File: rtl/acc_pkg.sv
// Shared constants and the control word type for the accumulator computer.
// Assumes a fixed 4-bit opcode field and a six-step instruction ring.
package acc_pkg;
    localparam int OP_W  = 4;
    localparam int STEPS = 6;

    localparam logic [OP_W-1:0] OP_LOAD = 4'h0;
    localparam logic [OP_W-1:0] OP_ADD  = 4'h1;
    localparam logic [OP_W-1:0] OP_SUB  = 4'h2;
    localparam logic [OP_W-1:0] OP_SHOW = 4'h3;
    localparam logic [OP_W-1:0] OP_STOP = 4'hF;

    typedef struct packed {
        logic pc_inc;    // advance program counter
        logic pc_drv;    // program counter onto bus
        logic mar_ld;    // address register loads from bus
        logic mem_drv;   // memory word onto bus
        logic ir_ld;     // instruction register loads from bus
        logic ir_drv;    // address field onto bus
        logic acc_ld;    // accumulator loads from bus
        logic acc_drv;   // accumulator onto bus
        logic alu_sub;   // subtract instead of add
        logic alu_drv;   // ALU result onto bus
        logic opr_ld;    // operand register loads from bus
        logic out_ld;    // output register loads from bus
        logic stop_set;  // raise halted
    } ctrl_word_t;
endpackage

// File: rtl/acc_mem.sv
// Unified program/data store: synchronous write, combinational read.
// Assumes the writer guarantees writes only happen while the machine is cleared.
module acc_mem #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] cells [DEPTH];

    // Store one preload word per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/acc_alu.sv
// Adder/subtractor; wraps modulo 2**DW and produces no flags.
module acc_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic          sub,
    output logic [DW-1:0] res
);
    // Select sum or difference.
    always_comb begin
        res = sub ? (lhs - rhs) : (lhs + rhs);
    end
endmodule

// File: rtl/acc_ctrl.sv
// Six-step ring-counter sequencer. Steps 1-3 fetch, steps 4-6 execute by opcode.
// Assumes opcode is stable from step 4 onward (loaded at the end of step 3).
module acc_ctrl
    import acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode,
    output ctrl_word_t       cw,
    output logic [STEPS-1:0] ring,
    output logic             halted
);
    // Rotate the one-hot step ring unless stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)       ring <= STEPS'(1);
        else if (!halted) ring <= {ring[STEPS-2:0], ring[STEPS-1]};
    end

    // Latch the stop condition until clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           halted <= 1'b0;
        else if (cw.stop_set) halted <= 1'b1;
    end

    // Decode step and opcode into the control word.
    always_comb begin
        cw = '0;
        if (!halted) begin
            if (ring[0]) begin
                cw.pc_drv = 1'b1;
                cw.mar_ld = 1'b1;
            end
            if (ring[1]) cw.pc_inc = 1'b1;
            if (ring[2]) begin
                cw.mem_drv = 1'b1;
                cw.ir_ld   = 1'b1;
            end
            if (ring[3]) begin
                case (opcode)
                    OP_LOAD, OP_ADD, OP_SUB: begin
                        cw.ir_drv = 1'b1;
                        cw.mar_ld = 1'b1;
                    end
                    OP_SHOW: begin
                        cw.acc_drv = 1'b1;
                        cw.out_ld  = 1'b1;
                    end
                    OP_STOP: cw.stop_set = 1'b1;
                    default: ;
                endcase
            end
            if (ring[4]) begin
                case (opcode)
                    OP_LOAD: begin
                        cw.mem_drv = 1'b1;
                        cw.acc_ld  = 1'b1;
                    end
                    OP_ADD, OP_SUB: begin
                        cw.mem_drv = 1'b1;
                        cw.opr_ld  = 1'b1;
                    end
                    default: ;
                endcase
            end
            if (ring[5]) begin
                if (opcode == OP_ADD || opcode == OP_SUB) begin
                    cw.alu_drv = 1'b1;
                    cw.acc_ld  = 1'b1;
                    cw.alu_sub = (opcode == OP_SUB);
                end
            end
        end
    end
endmodule

// File: rtl/acc_computer.sv
// Top level: registers, single shared bus, memory, ALU and sequencer.
// Assumes preload happens only while rst_n is low; the memory is not cleared.
module acc_computer
    import acc_pkg::*;
#(
    parameter  int ADDR_W = 4,
    localparam int DATA_W = OP_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    output logic [DATA_W-1:0] out_port,
    output logic              halted
);
    ctrl_word_t        cw;
    logic [STEPS-1:0]  ring;
    logic [ADDR_W-1:0] pc, mar;
    logic [DATA_W-1:0] ir, acc, opr, outr, bus, mem_q, alu_q;
    logic [4:0]        bus_drv;

    acc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (ir[DATA_W-1 -: OP_W]),
        .cw     (cw),
        .ring   (ring),
        .halted (halted)
    );

    acc_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk     (clk),
        .wr_en   (!rst_n && pre_we),
        .wr_addr (pre_addr),
        .wr_data (pre_data),
        .rd_addr (mar),
        .rd_data (mem_q)
    );

    acc_alu #(.DW(DATA_W)) u_alu (
        .lhs (acc),
        .rhs (opr),
        .sub (cw.alu_sub),
        .res (alu_q)
    );

    assign bus_drv = {cw.pc_drv, cw.mem_drv, cw.ir_drv, cw.acc_drv, cw.alu_drv};

    // Shared bus source selection.
    always_comb begin
        bus = '0;
        if (cw.pc_drv)  bus = {{OP_W{1'b0}}, pc};
        if (cw.mem_drv) bus = mem_q;
        if (cw.ir_drv)  bus = {{OP_W{1'b0}}, ir[ADDR_W-1:0]};
        if (cw.acc_drv) bus = acc;
        if (cw.alu_drv) bus = alu_q;
    end

    // Register loads from the bus and program counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc   <= '0;
            mar  <= '0;
            ir   <= '0;
            acc  <= '0;
            opr  <= '0;
            outr <= '0;
        end else begin
            if (cw.pc_inc) pc   <= pc + 1'b1;
            if (cw.mar_ld) mar  <= bus[ADDR_W-1:0];
            if (cw.ir_ld)  ir   <= bus;
            if (cw.acc_ld) acc  <= bus;
            if (cw.opr_ld) opr  <= bus;
            if (cw.out_ld) outr <= bus;
        end
    end

    assign out_port = outr;
endmodule

// File: rtl/acc_checker.sv
// Cycle-level protocol checks for acc_computer, attached by bind.
module acc_checker #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int STEPS  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        bus_drv,
    input logic [STEPS-1:0]  ring,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] out_port,
    input logic              halted
);
    assert_single_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_drv));

    // bus_drv[3] is the memory driver
    assert_mem_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drv[3] |-> (ring[2] || ring[4]));

    assert_ring_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ring) == 1);

    assert_pc_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ring[1] && !halted) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_out_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(out_port));

    assert_halt_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(ring[3]));

    assert_out_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_port != $past(out_port)) |-> $past(ring[3]));
endmodule

bind acc_computer acc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STEPS  (acc_pkg::STEPS)
) u_acc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_drv  (bus_drv),
    .ring     (ring),
    .pc       (pc),
    .out_port (out_port),
    .halted   (halted)
);

// File: tb/test_acc_computer.sv
// Bench: behavioural machine model stepped on every clock, compared each cycle.
module test_acc_computer;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [DW-1:0] pre_data = '0;
    logic [DW-1:0] out_port;
    logic          halted;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_mem [DEPTH];
    logic [3:0] m_pc, m_mar;
    logic [7:0] m_ir, m_a, m_b, m_out;
    bit         m_halt;
    int         m_step;

    acc_computer #(.ADDR_W(AW)) i_acc_computer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .out_port (out_port),
        .halted   (halted)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = 0; m_mar = 0; m_ir = 0; m_a = 0; m_b = 0; m_out = 0;
        m_halt = 0; m_step = 0;
    endtask

    task automatic model_step();
        logic [3:0] op;
        if (m_halt) return;
        op = m_ir[7:4];
        case (m_step)
            0: m_mar = m_pc;
            1: m_pc = m_pc + 4'd1;
            2: m_ir = m_mem[m_mar];
            3: begin
                if (op == 4'h0 || op == 4'h1 || op == 4'h2) m_mar = m_ir[3:0];
                else if (op == 4'h3) m_out = m_a;
                else if (op == 4'hF) m_halt = 1;
            end
            4: begin
                if (op == 4'h0) m_a = m_mem[m_mar];
                else if (op == 4'h1 || op == 4'h2) m_b = m_mem[m_mar];
            end
            default: begin
                if (op == 4'h1) m_a = m_a + m_b;
                else if (op == 4'h2) m_a = m_a - m_b;
            end
        endcase
        m_step = (m_step + 1) % 6;
    endtask

    // Advance n clocks, stepping the model and comparing at the falling edge.
    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            if (rst_n) model_step();
            else model_reset();
            @(negedge clk);
            check(out_port == m_out, "R5 out_port vs model", out_port, m_out);
            check(halted == m_halt, "R6 halted vs model", {7'd0, halted}, {7'd0, m_halt});
        end
    endtask

    task automatic load_prog(input logic [7:0] img [DEPTH]);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            pre_we = 1'b1;
            pre_addr = AW'(i);
            pre_data = img[i];
            m_mem[i] = img[i];
            tick(1);
        end
        pre_we = 1'b0;
        tick(1);
        check(out_port == 8'h00, "R10 reset out_port", out_port, 8'h00);
        check(halted == 1'b0, "R10 reset halted", {7'd0, halted}, 8'h00);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [7:0] p1 [DEPTH];
        logic [7:0] p2 [DEPTH];
        logic [7:0] p3 [DEPTH];
        logic [7:0] p4 [DEPTH];
        p1 = '{8'h09, 8'h1A, 8'h1B, 8'h2C, 8'h30, 8'hF0, 8'hFF, 8'hFF,
               8'hFF, 8'h01, 8'h04, 8'h02, 8'h03, 8'hFF, 8'hFF, 8'hFF};
        p2 = '{8'h08, 8'h29, 8'h30, 8'h7F, 8'h1A, 8'h30, 8'hF0, 8'hFF,
               8'h02, 8'h05, 8'h05, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        p3 = '{8'h0E, 8'h30, 8'hF0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
               8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h5A, 8'hFF};
        p4 = '{8'h0E, 8'h50, 8'h50, 8'h50, 8'h50, 8'h50, 8'h50, 8'h50,
               8'h50, 8'h50, 8'h50, 8'h50, 8'h50, 8'h50, 8'h77, 8'h30};

        // Program 1: load, two adds, subtract, output, halt -> 04h
        load_prog(p1);
        tick(33);
        check(halted == 1'b0, "R6 not halted before step 4 of halt", {7'd0, halted}, 8'h00);
        tick(1);
        check(halted == 1'b1, "R6 halted after step 4 of halt", {7'd0, halted}, 8'h01);
        check(out_port == 8'h04, "R1 R2 R3 R4 R9 program result", out_port, 8'h04);
        tick(10);
        check(out_port == 8'h04, "R6 output frozen while halted", out_port, 8'h04);

        // Program 2: subtract wraps, undefined opcode, add wraps
        load_prog(p2);
        tick(15);
        check(out_port == 8'h00, "R5 output not yet loaded", out_port, 8'h00);
        tick(1);
        check(out_port == 8'hFD, "R4 subtract wraps below zero", out_port, 8'hFD);
        tick(23);
        check(halted == 1'b0, "R7 no-op kept six cycles", {7'd0, halted}, 8'h00);
        tick(1);
        check(halted == 1'b1, "R7 halt at cycle 40", {7'd0, halted}, 8'h01);
        check(out_port == 8'h02, "R3 add wraps above 255", out_port, 8'h02);

        // Program 3: preload ignored while running, then mid-run clear
        load_prog(p3);
        tick(2);
        pre_we = 1'b1; pre_addr = 4'hE; pre_data = 8'h55;
        tick(1);
        pre_we = 1'b0;
        tick(14);
        check(out_port == 8'h5A, "R10 preload ignored while running", out_port, 8'h5A);
        rst_n = 1'b0;
        tick(2);
        check(out_port == 8'h00, "R10 clear resets output", out_port, 8'h00);
        check(halted == 1'b0, "R10 clear resets halted", {7'd0, halted}, 8'h00);
        rst_n = 1'b1;
        tick(20);
        check(out_port == 8'h5A, "R2 rerun after clear", out_port, 8'h5A);

        // Program 4: no-ops through the whole memory, output at last address
        load_prog(p4);
        tick(93);
        check(out_port == 8'h00, "R8 output before last address", out_port, 8'h00);
        tick(1);
        check(out_port == 8'h77, "R8 fetch reached address 15", out_port, 8'h77);
        tick(30);
        check(halted == 1'b0, "R7 R8 running after counter wrap", {7'd0, halted}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule